// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Generator

This block turns activity on two port C lines of several parallel I/O channels into one interrupt request for a host bus. In every channel, line 0 fires on a low-to-high transition and line 3 fires on a high-to-low transition. Both are taken from the pin state. A test interrupt therefore comes out the same way whether the pins are driven from outside or from the port's own output latch.

Each channel has a two-bit enable selection. The channel can be held off, held on, or left under software control, in which case port C line 4 at 0 enables it. Every detected edge on an enabled channel drives the shared request line high for a fixed number of clock cycles. After that the line is released, so several boards can wire their requests together. No record is kept of which line fired. Software reads the live lines 0 and 3 to find the source. A line has to return to its idle level (line 0 low, line 3 high) before it can fire again.

Top module: `edge_irq_gen`

## Requirements
- R1: While reset is held and after it is released with no edges, `irq_oe` and `irq_lvl` are 0.
- R2: A 0-to-1 change on `pc0_pin[k]` of an enabled channel k drives `irq_oe` and `irq_lvl` to 1 from the 3rd rising clock edge after the change, for PULSE_LEN cycles (4 by default). After that both return to 0.
- R3: A 1-to-0 change on `pc3_pin[k]` of an enabled channel gives the same pulse with the same timing as R2.
- R4: The opposite transitions, 1-to-0 on `pc0_pin` and 0-to-1 on `pc3_pin`, raise no request.
- R5: A line held at its active level raises no further request. A new pulse comes only after the line has returned to idle and changed again.
- R6: Channel k uses `en_sel[2k+1:2k]`. Code 2'b01 always enables the channel. Codes 2'b00 and 2'b11 disable it. Code 2'b10 enables it while `pc4_pin[k]` is 0. Edges on a disabled channel raise nothing.
- R7: If a channel's selection changes to a disabled code while its pulse is running, its drive ends at the next rising clock edge.
- R8: Requests from all channels are ORed onto the one line. An edge that arrives while the line is already driven restarts the PULSE_LEN count from that edge.
- R9: `irq_lvl` is 1 only while `irq_oe` is 1. When not driving, the line is released with both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc0_pin | input | NCH | Pin state of port C line 0 per channel (rising-edge source) |
| pc3_pin | input | NCH | Pin state of port C line 3 per channel (falling-edge source) |
| pc4_pin | input | NCH | Pin state of port C line 4 per channel (software enable, 0 = on) |
| en_sel | input | 2*NCH | Per-channel enable selection, two bits per channel |
| irq_lvl | output | 1 | Request level driven onto the shared line |
| irq_oe | output | 1 | Output enable for the shared line; 0 releases it |

## Verification
The assertions assume that the pin inputs are asynchronous and pass only through the synchroniser chain. They also assume that `en_sel` is quasi-static and that each pin change lasts several clock cycles, so every transition is seen as one edge. The stimulus changes pins and selections only on the falling clock edge. It holds every level for at least two cycles and puts each line back at its idle level before the next trigger. Retriggers and simultaneous edges are applied on purpose, so the restart and OR paths are exercised under those same assumptions.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   typedef enum logic [1:0] {
      EN_OFF  = 2'b00,
      EN_ON   = 2'b01,
      EN_SW   = 2'b10,
      EN_OFF2 = 2'b11
   } en_sel_e;

   // Resolve a selection code against the synchronised software bit (0 = on)
   function automatic logic sel_enabled(input logic [1:0] sel, input logic sw_bit);
      logic r;
      case (en_sel_e'(sel))
         EN_ON:   r = 1'b1;
         EN_SW:   r = ~sw_bit;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= {STAGES{RST_VAL}};
      else        shreg <= {shreg[STAGES-2:0], d};
   end

   assign q = shreg[STAGES-1];

endmodule

// File: rtl/edge_chan.sv
module edge_chan
   import edge_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_LEN   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pc0,
   input  logic       pc3,
   input  logic       pc4,
   input  logic [1:0] sel,
   output logic       req
);

   localparam int CW = $clog2(PULSE_LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

   logic s0, s3, s4;
   logic d0, d3;
   logic rise, fall, en, trig;
   logic [CW-1:0] cnt;

   // Synchronisers reset to the idle level of each line
   bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_s0 (.clk(clk), .rst_n(rst_n), .d(pc0), .q(s0));
   bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_s3 (.clk(clk), .rst_n(rst_n), .d(pc3), .q(s3));
   bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_s4 (.clk(clk), .rst_n(rst_n), .d(pc4), .q(s4));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d0 <= 1'b0;
         d3 <= 1'b1;
      end else begin
         d0 <= s0;
         d3 <= s3;
      end
   end

   assign rise = s0 & ~d0;
   assign fall = ~s3 & d3;
   assign en   = sel_enabled(sel, s4);
   assign trig = en & (rise | fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (trig)       cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign req = (cnt != '0);

   // Assertion support: cycles since the last accepted edge, saturating
   logic [CW-1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age <= LOAD;
      else if (trig)         age <= '0;
      else if (age != LOAD)  age <= age + 1'b1;
   end

   a_r2_rise_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rise) |=> req);

   a_r3_fall_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (en && fall) |=> req);

   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !(en && (rise || fall))) |=> !req);

   a_r7_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !req);

   a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (age < LOAD));

endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int NCH = 6
) (
   input  logic [NCH-1:0] reqs,
   output logic           lvl,
   output logic           oe
);

   assign oe  = |reqs;
   assign lvl = oe;

endmodule

// File: rtl/edge_irq_gen.sv
module edge_irq_gen
   import edge_irq_pkg::*;
#(
   parameter int NCH         = 6,
   parameter int PULSE_LEN   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   pc0_pin,
   input  logic [NCH-1:0]   pc3_pin,
   input  logic [NCH-1:0]   pc4_pin,
   input  logic [2*NCH-1:0] en_sel,
   output logic             irq_lvl,
   output logic             irq_oe
);

   localparam int SELW = 2 * NCH;

   if (NCH < 1)         begin : g_bad_nch   $error("NCH must be at least 1");         end
   if (PULSE_LEN < 1)   begin : g_bad_len   $error("PULSE_LEN must be at least 1");   end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [NCH-1:0] chan_req;
   logic [NCH-1:0] chan_off;

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      edge_chan #(
         .SYNC_STAGES(SYNC_STAGES),
         .PULSE_LEN  (PULSE_LEN)
      ) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .pc0  (pc0_pin[k]),
         .pc3  (pc3_pin[k]),
         .pc4  (pc4_pin[k]),
         .sel  (en_sel[2*k +: 2]),
         .req  (chan_req[k])
      );
      assign chan_off[k] = (en_sel[2*k +: 2] == EN_OFF) || (en_sel[2*k +: 2] == EN_OFF2);
   end

   irq_merge #(.NCH(NCH)) u_merge (
      .reqs(chan_req),
      .lvl (irq_lvl),
      .oe  (irq_oe)
   );

   logic all_off;
   assign all_off = &chan_off;

   a_r6_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(all_off) |-> !irq_oe);

   a_r9_lvl_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lvl |-> irq_oe);

   logic unused_w;
   assign unused_w = ^SELW;

endmodule

// File: tb/sim_edge_irq_gen.sv
module sim_edge_irq_gen;

   localparam int NCH = 6;
   localparam int PL  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   p0 = '0;
   logic [NCH-1:0]   p3 = '1;
   logic [NCH-1:0]   p4 = '1;
   logic [2*NCH-1:0] sel = '0;
   logic             irq_lvl, irq_oe;

   int cyc = 0;
   int checks = 0;
   int fails = 0;

   typedef struct {
      int    at;
      logic  exp;
      string tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   edge_irq_gen #(.NCH(NCH), .PULSE_LEN(PL), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .pc0_pin(p0), .pc3_pin(p3), .pc4_pin(p4),
      .en_sel(sel),
      .irq_lvl(irq_lvl), .irq_oe(irq_oe)
   );

   task automatic push(input int off, input logic e, input string tag);
      exp_t it;
      it.at = cyc + off; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic expect_low(input int from, input int to, input string tag);
      for (int k = from; k <= to; k++) push(k, 1'b0, tag);
   endtask

   task automatic expect_pulse(input string tag);
      expect_low(1, 2, tag);
      for (int k = 3; k < 3 + PL; k++) push(k, 1'b1, tag);
      expect_low(3 + PL, 5 + PL, tag);
   endtask

   task automatic settle();
      repeat (12) @(negedge clk);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   // Monitor: pops due expectations and compares at the falling edge
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            checks++;
            if (irq_oe !== e.exp || irq_lvl !== e.exp) begin
               fails++;
               $display("FAIL %s cyc %0d: oe=%b lvl=%b expected %b", e.tag, cyc, irq_oe, irq_lvl, e.exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      report();
   end

   initial begin
      // R1: in reset
      repeat (3) @(negedge clk);
      checks++;
      if (irq_oe !== 1'b0 || irq_lvl !== 1'b0) begin
         fails++;
         $display("FAIL R1 in reset: oe=%b lvl=%b expected 0", irq_oe, irq_lvl);
      end
      rst_n = 1'b1;
      sel = 12'h555;                    // all channels: code 01, always on
      expect_low(1, 6, "R1");
      settle();

      // R2: rising edge on line 0 of channel 0
      p0[0] = 1'b1; expect_pulse("R2");
      settle();
      // R4: falling line 0 is not a trigger (also returns it to idle)
      p0[0] = 1'b0; expect_low(1, 9, "R4");
      settle();

      // R3: falling edge on line 3 of channel 2
      p3[2] = 1'b0; expect_pulse("R3");
      settle();
      // R4: rising line 3 is not a trigger
      p3[2] = 1'b1; expect_low(1, 9, "R4");
      settle();

      // R5: held active level does not retrigger
      p0[1] = 1'b1; expect_pulse("R5");
      settle();
      expect_low(1, 12, "R5");
      settle();
      p0[1] = 1'b0; expect_low(1, 9, "R5");
      settle();
      p0[1] = 1'b1; expect_pulse("R5");
      settle();

      // R6: selection codes on channel 3
      sel[7:6] = 2'b00;
      settle();
      p0[3] = 1'b1; expect_low(1, 9, "R6");
      settle();
      p0[3] = 1'b0; sel[7:6] = 2'b11;
      settle();
      p0[3] = 1'b1; expect_low(1, 9, "R6");
      settle();
      p0[3] = 1'b0; sel[7:6] = 2'b10;   // software control, pc4 still 1
      settle();
      p0[3] = 1'b1; expect_low(1, 9, "R6");
      settle();
      p0[3] = 1'b0; p4[3] = 1'b0;       // software enable on
      settle();
      p0[3] = 1'b1; expect_pulse("R6");
      settle();

      // R7: disable during a pulse on channel 4
      p0[4] = 1'b1;
      expect_low(1, 2, "R7");
      push(3, 1'b1, "R7"); push(4, 1'b1, "R7");
      expect_low(5, 9, "R7");
      repeat (4) @(negedge clk);
      sel[9:8] = 2'b00;
      settle();

      // R8: simultaneous edges on two channels give one pulse
      p0[0] = 1'b1; p3[2] = 1'b0; expect_pulse("R8");
      settle();
      p0[0] = 1'b0; p3[2] = 1'b1;
      settle();
      // R8: second edge two cycles later restarts the count
      p0[0] = 1'b1;
      expect_low(1, 2, "R8");
      for (int k = 3; k <= 2 + 2 + PL; k++) push(k, 1'b1, "R8");
      expect_low(3 + 2 + PL, 6 + 2 + PL, "R8");
      repeat (2) @(negedge clk);
      p3[2] = 1'b0;
      settle();

      // R9: both outputs released at the end
      expect_low(1, 4, "R9");
      settle();

      while (q.size() > 0) @(negedge clk);
      report();
   end

endmodule